// File: doc/BRIEF.md
# Ripple-Cancelling Duty Correction Sequencer

This block works out the duty-cycle correction that keeps a boost stage's input voltage steady while its output bus carries a low-frequency ripple. A single start strobe captures the input-voltage and output-voltage samples. The block then runs a fixed sequence of steps around one shared multiplier.

1. The input sample is scaled by a constant `K_VAL`. This constant absorbs the converter gain and offset and the scaling of the output word.
2. The scaled value goes to an external divider, with the captured output sample as denominator.
3. The quotient returns through the operand multiplexers and is multiplied by the band-pass-filtered ripple value.
4. Because the DC output level is a power of two, the final division is an arithmetic right shift by `SHIFT` bits.
5. The result is clamped to a signed 10-bit window, which is half of the 1024-count modulator range on each side of zero.

The ripple filter runs in parallel on the same output sample, outside this block. The filter's result must be present on `ripple` from start until the result is valid. The divider is also external and is reached through a request/done handshake.

Top module: `dcorr_gen`

## Requirements
- R1: During and after a synchronous active-high reset, `div_req` and `corr_valid` are 0 and `corr` is 0.
- R2: While `div_req` is high, `div_num` equals `vin_smp`×`K_VAL` and `div_den` equals `vout_smp`, both taken at the edge where `start` was accepted, and both stay unchanged.
- R3: `div_req` is still 0 one cycle after the start edge. It is 1 after the second edge following the accepted start. It stays 1 until an edge samples `div_done` high, and it is 0 after that edge.
- R4: The result equals floor(`div_quo`×`ripple` / 2^`SHIFT`), with `ripple` taken as two's complement. At default parameters this is floor(floor(`vin`×1024/`vout`)×`ripple` / 4096).
- R5: Results above +511 are output as +511, and results below −512 are output as −512, in two's complement on 10 bits.
- R6: `corr_valid` is high for exactly one cycle. It follows the second clock edge after the edge that accepted `div_done`.
- R7: A `start` pulse while a computation is in progress is ignored. It produces no extra request or result and does not alter the result in flight.
- R8: Changes on `vin_smp` and `vout_smp` after the accepted start do not affect that computation.
- R9: `corr` keeps its value between `corr_valid` pulses.
- R10: A `div_done` that arrives in the first request cycle (a zero-wait divider) is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a computation when idle |
| vin_smp | input | SMP_W | Unsigned input-voltage sample |
| vout_smp | input | SMP_W | Unsigned output-voltage sample, nonzero |
| ripple | input | RIP_W | Signed filtered ripple component |
| div_req | output | 1 | Divider request, held until done |
| div_num | output | NUM_W | Dividend for the divider |
| div_den | output | SMP_W | Divisor for the divider |
| div_done | input | 1 | Divider result ready |
| div_quo | input | NUM_W | Unsigned quotient from the divider |
| corr | output | OUT_W | Signed saturated correction |
| corr_valid | output | 1 | One-cycle result strobe |

## Verification
The properties assume that `div_done` is high only while `div_req` is high, that it lasts one cycle, and that `div_quo` is valid while it is high. They also assume a nonzero `vout_smp`, and a `ripple` held steady until the result appears. The bench's divider model answers only to a raised request, with a wait of zero to six cycles. It drops `div_done` one cycle later and returns the exact integer quotient. Every sequence keeps `ripple` constant from start to result, and all output samples are drawn from 1 to 4095. Inputs change only on falling edges.

// File: rtl/dcorr_pkg.sv
package dcorr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL1,
        ST_DIV_REQ,
        ST_DIV_WAIT,
        ST_MUL2,
        ST_SHIFT,
        ST_DONE
    } dc_state_e;

    // Operand-pair selection for the shared multiplier
    typedef enum logic {
        OPS_SCALE,   // input sample x constant
        OPS_RIPPLE   // quotient x filtered ripple
    } dc_opsel_e;

    typedef struct packed {
        logic      cap;      // capture samples
        logic      ld_prod;  // load multiplier result
        logic      ld_quo;   // load divider quotient
        logic      ld_res;   // load shifted, clamped result
        dc_opsel_e sel;
        logic      req;
        logic      valid;
    } dc_ctrl_t;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcorr_ctrl.sv
module dcorr_ctrl
    import dcorr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     div_done,
    output dc_ctrl_t ctl
);

    dc_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        ctl     = '0;
        ctl.sel = OPS_SCALE;
        st_nx   = st;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    ctl.cap = 1'b1;
                    st_nx   = ST_MUL1;
                end
            end
            ST_MUL1: begin
                ctl.sel     = OPS_SCALE;
                ctl.ld_prod = 1'b1;
                st_nx       = ST_DIV_REQ;
            end
            ST_DIV_REQ: begin
                ctl.req = 1'b1;
                if (div_done) begin
                    ctl.ld_quo = 1'b1;
                    st_nx      = ST_MUL2;
                end else begin
                    st_nx      = ST_DIV_WAIT;
                end
            end
            ST_DIV_WAIT: begin
                ctl.req = 1'b1;
                if (div_done) begin
                    ctl.ld_quo = 1'b1;
                    st_nx      = ST_MUL2;
                end
            end
            ST_MUL2: begin
                ctl.sel     = OPS_RIPPLE;
                ctl.ld_prod = 1'b1;
                st_nx       = ST_SHIFT;
            end
            ST_SHIFT: begin
                ctl.ld_res = 1'b1;
                st_nx      = ST_DONE;
            end
            ST_DONE: begin
                ctl.valid = 1'b1;
                st_nx     = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dcorr_mulpath.sv
module dcorr_mulpath
    import dcorr_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int QUO_W = 23,
    parameter int RIP_W = 12,
    parameter int K_VAL = 1024,
    parameter int A_W   = 24,
    parameter int B_W   = 12
) (
    input  dc_opsel_e                 sel,
    input  logic [SMP_W-1:0]          vin,
    input  logic [QUO_W-1:0]          quo,
    input  logic signed [RIP_W-1:0]   ripple,
    output logic signed [A_W+B_W-1:0] prod
);

    localparam logic signed [B_W-1:0] K_OP = B_W'(K_VAL);

    logic signed [A_W-1:0] opa;
    logic signed [B_W-1:0] opb;

    // Two operand multiplexers feeding one multiplier
    always_comb begin
        unique case (sel)
            OPS_SCALE: begin
                opa = A_W'(vin);
                opb = K_OP;
            end
            default: begin
                opa = A_W'(quo);
                opb = B_W'(ripple);
            end
        endcase
        prod = opa * opb;
    end

endmodule

// File: rtl/dcorr_sat.sv
module dcorr_sat #(
    parameter int P_W   = 36,
    parameter int SHIFT = 12,
    parameter int OUT_W = 10
) (
    input  logic signed [P_W-1:0]   prod,
    output logic signed [OUT_W-1:0] corr
);

    localparam logic signed [P_W-1:0] HI = P_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [P_W-1:0] LO = ~HI;

    logic signed [P_W-1:0] sh;

    always_comb begin
        sh = prod >>> SHIFT;
        if (sh > HI)      corr = HI[OUT_W-1:0];
        else if (sh < LO) corr = LO[OUT_W-1:0];
        else              corr = sh[OUT_W-1:0];
    end

endmodule

// File: rtl/dcorr_gen.sv
module dcorr_gen
    import dcorr_pkg::*;
#(
    parameter  int SMP_W = 12,
    parameter  int RIP_W = 12,
    parameter  int K_VAL = 1024,
    parameter  int SHIFT = 12,
    parameter  int OUT_W = 10,
    localparam int K_W   = $clog2(K_VAL + 1),
    localparam int NUM_W = SMP_W + K_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [SMP_W-1:0]        vin_smp,
    input  logic [SMP_W-1:0]        vout_smp,
    input  logic signed [RIP_W-1:0] ripple,
    output logic                    div_req,
    output logic [NUM_W-1:0]        div_num,
    output logic [SMP_W-1:0]        div_den,
    input  logic                    div_done,
    input  logic [NUM_W-1:0]        div_quo,
    output logic signed [OUT_W-1:0] corr,
    output logic                    corr_valid
);

    localparam int QUO_W = NUM_W;
    localparam int A_W   = QUO_W + 1;
    localparam int B_W   = max_i(K_W + 1, RIP_W);
    localparam int P_W   = A_W + B_W;

    dc_ctrl_t ctl;

    logic [SMP_W-1:0]        vin_q, vout_q;
    logic [QUO_W-1:0]        quo_q;
    logic signed [P_W-1:0]   prod_q, prod_d;
    logic signed [OUT_W-1:0] corr_q, corr_d;

    dcorr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .div_done (div_done),
        .ctl      (ctl)
    );

    dcorr_mulpath #(
        .SMP_W (SMP_W),
        .QUO_W (QUO_W),
        .RIP_W (RIP_W),
        .K_VAL (K_VAL),
        .A_W   (A_W),
        .B_W   (B_W)
    ) u_mul (
        .sel    (ctl.sel),
        .vin    (vin_q),
        .quo    (quo_q),
        .ripple (ripple),
        .prod   (prod_d)
    );

    dcorr_sat #(
        .P_W   (P_W),
        .SHIFT (SHIFT),
        .OUT_W (OUT_W)
    ) u_sat (
        .prod (prod_q),
        .corr (corr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vin_q  <= '0;
            vout_q <= '0;
            quo_q  <= '0;
            prod_q <= '0;
            corr_q <= '0;
        end else begin
            if (ctl.cap) begin
                vin_q  <= vin_smp;
                vout_q <= vout_smp;
            end
            if (ctl.ld_prod) prod_q <= prod_d;
            if (ctl.ld_quo)  quo_q  <= div_quo;
            if (ctl.ld_res)  corr_q <= corr_d;
        end
    end

    assign div_req    = ctl.req;
    assign div_num    = prod_q[NUM_W-1:0];
    assign div_den    = vout_q;
    assign corr       = corr_q;
    assign corr_valid = ctl.valid;

endmodule

// File: rtl/dcorr_gen_chk.sv
module dcorr_gen_chk #(
    parameter int NUM_W = 23,
    parameter int SMP_W = 12,
    parameter int OUT_W = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    div_req,
    input logic                    div_done,
    input logic [NUM_W-1:0]        div_num,
    input logic [SMP_W-1:0]        div_den,
    input logic signed [OUT_W-1:0] corr,
    input logic                    corr_valid
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!div_req && !corr_valid));

    p_oper_steady_r2: assert property (@(posedge clk) disable iff (rst)
        (div_req && !div_done) |=> ($stable(div_num) && $stable(div_den)));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (div_req && !div_done) |=> div_req);

    p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (div_req && div_done) |=> !div_req);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        corr_valid |=> !corr_valid);

    p_valid_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        (div_req && div_done) |=> ##2 corr_valid);

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
        corr_valid |-> !div_req);

    p_corr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !corr_valid |=> (corr_valid || $stable(corr)));

endmodule

bind dcorr_gen dcorr_gen_chk #(
    .NUM_W (NUM_W),
    .SMP_W (SMP_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .div_req    (div_req),
    .div_done   (div_done),
    .div_num    (div_num),
    .div_den    (div_den),
    .corr       (corr),
    .corr_valid (corr_valid)
);

// File: tb/tb_dcorr_gen.sv
`timescale 1ns/1ps
module tb_dcorr_gen;

    localparam int SMP_W = 12;
    localparam int RIP_W = 12;
    localparam int K_VAL = 1024;
    localparam int SHIFT = 12;
    localparam int OUT_W = 10;
    localparam int NUM_W = SMP_W + $clog2(K_VAL + 1);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic [SMP_W-1:0]        vin_smp = '0;
    logic [SMP_W-1:0]        vout_smp = SMP_W'(1);
    logic signed [RIP_W-1:0] ripple = '0;
    logic                    div_req;
    logic [NUM_W-1:0]        div_num;
    logic [SMP_W-1:0]        div_den;
    logic                    div_done = 1'b0;
    logic [NUM_W-1:0]        div_quo = '0;
    logic signed [OUT_W-1:0] corr;
    logic                    corr_valid;

    dcorr_gen #(
        .SMP_W (SMP_W),
        .RIP_W (RIP_W),
        .K_VAL (K_VAL),
        .SHIFT (SHIFT),
        .OUT_W (OUT_W)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .vin_smp    (vin_smp),
        .vout_smp   (vout_smp),
        .ripple     (ripple),
        .div_req    (div_req),
        .div_num    (div_num),
        .div_den    (div_den),
        .div_done   (div_done),
        .div_quo    (div_quo),
        .corr       (corr),
        .corr_valid (corr_valid)
    );

    always #2 clk = ~clk;

    int     n_cmp = 0;
    int     n_bad = 0;
    longint cyc = 0;
    longint done_cyc = -100;
    longint exp_num = 0;
    longint exp_den = 0;
    int     lat_cfg = 0;
    int     exp_q[$];
    bit     finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int model(input int vin, input int vout, input int rip);
        longint q, p, s;
        q = (longint'(vin) * K_VAL) / vout;
        p = q * rip;
        s = p >>> SHIFT;
        if (s > 511)  s = 511;
        if (s < -512) s = -512;
        return int'(s);
    endfunction

    // External divider model
    initial begin
        forever begin
            @(negedge clk);
            if (div_req && !div_done) begin
                check(div_num == NUM_W'(exp_num), "R2 dividend", longint'(div_num), exp_num);
                check(div_den == SMP_W'(exp_den), "R2 divisor", longint'(div_den), exp_den);
                for (int i = 0; i < lat_cfg; i++) begin
                    @(negedge clk);
                    check(div_req, "R3 request held", longint'(div_req), 1);
                    check(div_num == NUM_W'(exp_num) && div_den == SMP_W'(exp_den),
                          "R2 operands steady", longint'(div_num), exp_num);
                end
                div_quo  = div_num / NUM_W'(div_den);
                div_done = 1'b1;
                done_cyc = cyc;
                @(negedge clk);
                check(!div_req, "R3 request dropped", longint'(div_req), 0);
                div_done = 1'b0;
            end
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        int e;
        if (!rst && corr_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected result", longint'(corr), 0);
            end else begin
                e = exp_q.pop_front();
                check(corr == OUT_W'(e), "R4 R5 correction value", longint'(corr), longint'(e));
                check(cyc == done_cyc + 3, "R6 valid timing", cyc - done_cyc, 3);
            end
        end
    end

    task automatic run(input int vin, input int vout, input int rip, input int lat,
                       input bit disturb, input bit restart);
        int e;
        e = model(vin, vout, rip);
        @(negedge clk);
        vin_smp  = SMP_W'(vin);
        vout_smp = SMP_W'(vout);
        ripple   = RIP_W'(rip);
        lat_cfg  = lat;
        exp_num  = longint'(vin) * K_VAL;
        exp_den  = vout;
        exp_q.push_back(e);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!div_req, "R3 no request one cycle after start", longint'(div_req), 0);
        if (disturb) begin
            vin_smp  = SMP_W'(4095 - vin);
            vout_smp = SMP_W'(vout / 2 + 1);
        end
        @(negedge clk);
        check(div_req, "R3 request two edges after start", longint'(div_req), 1);
        if (restart) begin
            start    = 1'b1;
            vin_smp  = SMP_W'(17);
            vout_smp = SMP_W'(9);
            @(negedge clk);
            start = 1'b0;
        end
        while (!corr_valid) @(negedge clk);
        @(negedge clk);
        check(!corr_valid, "R6 single-cycle strobe", longint'(corr_valid), 0);
        check(corr == OUT_W'(e), "R9 result held", longint'(corr), longint'(e));
        if (restart) begin
            repeat (6) @(negedge clk);
            check(!div_req && !corr_valid, "R7 busy start ignored",
                  longint'({div_req, corr_valid}), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!div_req && !corr_valid && corr == '0, "R1 reset outputs",
              longint'({div_req, corr_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!div_req && !corr_valid && corr == '0, "R1 idle after reset",
              longint'(corr), 0);

        run(1000, 3000,   500, 2, 0, 0);   // R4 typical
        run(1000, 3000,  -777, 1, 0, 0);   // R4 negative ripple
        run(1,    1024,    -1, 0, 0, 0);   // R4 floor to -1, R10 zero-wait divider
        run(2000, 2000,  2047, 0, 0, 0);   // R10, R4 just below top
        run(2000, 2000, -2048, 3, 0, 0);   // R5 exact lower bound
        run(4000, 1000,  2047, 3, 0, 0);   // R5 clamp high
        run(4000, 1000, -2048, 4, 0, 0);   // R5 clamp low
        run(2000, 2000,     0, 1, 0, 0);   // R4 zero ripple
        run(1500, 2500,   300, 5, 1, 0);   // R8 samples disturbed
        run(1500, 2500,  -300, 3, 0, 1);   // R7 start while busy
        for (int k = 0; k < 20; k++) begin
            run(int'($urandom_range(4095, 0)), int'($urandom_range(4095, 1)),
                int'($urandom_range(4095, 0)) - 2048, int'($urandom_range(6, 0)),
                k[0], k[1] & k[2]);
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 every result delivered", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule